// File: doc/BRIEF.md
# Multi-Cycle Shared-Memory Processor Datapath

This block is the datapath half of a processor that spends several clock cycles on each instruction. One memory holds both instructions and data, and one ALU does every calculation. Each cycle, an external sequencer drives a set of select and enable lines. Between cycles, results are held in internal registers: the program counter, the instruction register, two operand latches, the ALU result latch and the memory data latch.

The datapath also contains a 32-entry register file, a sign extender, and the multiplexers that feed the ALU and pick the next program counter value. Several signals go back to the sequencer so it can choose its next step: the opcode and function fields of the held instruction, and the ALU zero flag. The memory array sits outside the block. The block drives the memory address and write data and takes the read data back combinationally. Memory is word-addressed through address bits [31:2], and a write happens on the clock edge while the sequencer holds its memory-write line.

Top module: `mc_datapath`

## Requirements
- R1: After reset is deasserted, the following hold until the first enabled write:
  - the program counter holds RESET_PC (default 0);
  - the instruction register is zero, so `opcode` and `funct` read 0;
  - every register file entry reads 0.
- R2: The memory address is selected by `addr_sel`:
  - with `addr_sel`=0 it is the program counter;
  - with `addr_sel`=1 it is the latched ALU result.
- R3: The instruction register loads `mem_rdata` only on an edge where `ir_wr` is high. At all other times it keeps its value. `opcode` shows IR[31:26] and `funct` shows IR[5:0].
- R4: `a_sel` picks the first ALU operand: 0 gives the program counter and 1 gives the A latch. When `b_sel`=01 the second operand is the constant 4. `alu_mode`=00 forces an add. With `pc_src`=00 and `pc_wr` high, the program counter loads the live ALU output. Under the selects named here, that output is PC+4.
- R5: `b_sel` also selects the immediate forms of the second operand:
  - `b_sel`=10 gives IR[15:0] sign-extended to 32 bits;
  - `b_sel`=11 gives the same value shifted left by 2;
  - `b_sel`=00 gives the B latch.
- R6: `alu_mode`=01 forces a subtract. `alu_zero` is high exactly when the live ALU result is all zeros.
- R7: With `alu_mode`=10, the funct field chooses the operation:
  - 100000 is add;
  - 100010 is subtract;
  - 100100 is bitwise AND;
  - 100101 is bitwise OR;
  - 101010 is signed set-on-less-than, giving 1 or 0.
- R8: The program counter can load conditionally. When `pc_wr_if_zero` is high and `alu_zero` is high, it loads the source chosen by `pc_src`; `pc_src`=01 gives the latched ALU result. When `alu_zero` is low and `pc_wr` is low, the program counter does not change.
- R9: With `pc_src`=10 and `pc_wr` high, the program counter loads {PC[31:28], IR[25:0], 2'b00}.
- R10: When `rf_wr` is high, the register file is written at the clock edge.
  - The destination is IR[20:16] when `dst_sel`=0 and IR[15:11] when `dst_sel`=1.
  - The write data is the latched ALU result when `wb_sel`=0 and the memory data latch when `wb_sel`=1.
  - The register read ports are addressed by IR[25:21] (A) and IR[20:16] (B).
- R11: Register 0 always reads zero, and writes to it have no effect.
- R12: The latches A, B, ALU result and memory data capture their inputs on every clock edge. `mem_wdata` always shows the B latch, so a value read from a register leaves on `mem_wdata` after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Memory address source: 0 program counter, 1 ALU result latch |
| a_sel | input | 1 | First ALU operand: 0 program counter, 1 A latch |
| b_sel | input | 2 | Second ALU operand: 00 B, 01 four, 10 immediate, 11 immediate<<2 |
| alu_mode | input | 2 | 00 add, 01 subtract, 10 decode funct |
| pc_src | input | 2 | Next PC: 00 live ALU, 01 ALU latch, 10 jump target |
| pc_wr | input | 1 | Unconditional program counter write |
| pc_wr_if_zero | input | 1 | Program counter write when ALU zero is set |
| ir_wr | input | 1 | Instruction register load enable |
| rf_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination field: 0 IR[20:16], 1 IR[15:11] |
| wb_sel | input | 1 | Write data: 0 ALU latch, 1 memory data latch |
| mem_rdata | input | 32 | Combinational memory read data |
| mem_addr | output | 32 | Byte address to memory |
| mem_wdata | output | 32 | Store data (B latch) |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| alu_zero | output | 1 | Live ALU result is zero |

## Verification
The hardest state to reach from the ports is a known value inside the register file. No port reads the register file directly. Every value has to arrive through a fetched load that runs through address calculation, the memory cycle and write-back. It then has to come back out through a fetch and decode that leaves it in the B latch, where it appears on `mem_wdata`. The bench acts as the sequencer. Before each fetch it places the instruction word at its own predicted program counter. Each ALU vector then becomes two loads, one register-register operation and one read-back. The ALU result latch is observed by switching `addr_sel` to 1 in the cycle just after the edge that captured it.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  typedef enum logic [1:0] {
    BSRC_REG   = 2'b00,
    BSRC_FOUR  = 2'b01,
    BSRC_IMM   = 2'b10,
    BSRC_IMMSH = 2'b11
  } bsrc_e;

  typedef enum logic [1:0] {
    AMODE_ADD  = 2'b00,
    AMODE_SUB  = 2'b01,
    AMODE_FUNC = 2'b10,
    AMODE_RSVD = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    PSRC_LIVE  = 2'b00,
    PSRC_LATCH = 2'b01,
    PSRC_JUMP  = 2'b10,
    PSRC_RSVD  = 2'b11
  } psrc_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_SLT = 3'd4
  } alu_fn_e;

  localparam logic [5:0] FC_ADD = 6'b100000;
  localparam logic [5:0] FC_SUB = 6'b100010;
  localparam logic [5:0] FC_AND = 6'b100100;
  localparam logic [5:0] FC_OR  = 6'b100101;
  localparam logic [5:0] FC_SLT = 6'b101010;
endpackage

// File: rtl/mcd_alu_ctrl.sv
module mcd_alu_ctrl
  import mcd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [5:0] fcode,
  output alu_fn_e    fn
);
  always_comb begin
    fn = FN_ADD;
    unique case (amode_e'(mode))
      AMODE_SUB: fn = FN_SUB;
      AMODE_FUNC: begin
        case (fcode)
          FC_SUB:  fn = FN_SUB;
          FC_AND:  fn = FN_AND;
          FC_OR:   fn = FN_OR;
          FC_SLT:  fn = FN_SLT;
          default: fn = FN_ADD;
        endcase
      end
      default: fn = FN_ADD;
    endcase
  end
endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] result,
  output logic            is_zero
);
  always_comb begin
    unique case (fn)
      FN_SUB:  result = op_a - op_b;
      FN_AND:  result = op_a & op_b;
      FN_OR:   result = op_a | op_b;
      FN_SLT:  result = {{(XLEN-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
      default: result = op_a + op_b;
    endcase
  end

  assign is_zero = (result == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int XLEN    = 32,
  parameter int REG_CNT = 32,
  localparam int REG_AW = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] rd_idx_a,
  input  logic [REG_AW-1:0] rd_idx_b,
  output logic [XLEN-1:0]   rd_val_a,
  output logic [XLEN-1:0]   rd_val_b,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_val
);
  logic [XLEN-1:0] store_q [1:REG_CNT-1];

  for (genvar g = 1; g < REG_CNT; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == REG_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   store_q[g] <= '0;
      else if (hit) store_q[g] <= wr_val;
    end
  end

  always_comb begin
    rd_val_a = '0;
    rd_val_b = '0;
    for (int i = 1; i < REG_CNT; i++) begin
      if (rd_idx_a == REG_AW'(i)) rd_val_a = store_q[i];
      if (rd_idx_b == REG_AW'(i)) rd_val_b = store_q[i];
    end
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          REG_CNT  = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_sel,
  input  logic        a_sel,
  input  logic [1:0]  b_sel,
  input  logic [1:0]  alu_mode,
  input  logic [1:0]  pc_src,
  input  logic        pc_wr,
  input  logic        pc_wr_if_zero,
  input  logic        ir_wr,
  input  logic        rf_wr,
  input  logic        dst_sel,
  input  logic        wb_sel,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        alu_zero
);
  localparam int REG_AW = $clog2(REG_CNT);
  localparam int IMM_W  = 16;
  localparam int JMP_W  = 26;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ir_q, ir_d;
  logic [XLEN-1:0] a_q, a_d;
  logic [XLEN-1:0] b_q, b_d;
  logic [XLEN-1:0] res_q, res_d;
  logic [XLEN-1:0] mdr_q, mdr_d;

  logic [XLEN-1:0]   rf_a, rf_b, rf_wval;
  logic [REG_AW-1:0] rf_widx;
  logic [XLEN-1:0]   imm_ext, alu_in_a, alu_in_b, alu_y, pc_pick;
  alu_fn_e           alu_fn;
  logic              pc_load;

  // Operand fields from the held instruction
  assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign rf_widx = dst_sel ? ir_q[RD_LSB +: REG_AW] : ir_q[RT_LSB +: REG_AW];
  assign rf_wval = wb_sel ? mdr_q : res_q;

  mcd_regfile #(.XLEN(XLEN), .REG_CNT(REG_CNT)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_a (ir_q[RS_LSB +: REG_AW]),
    .rd_idx_b (ir_q[RT_LSB +: REG_AW]),
    .rd_val_a (rf_a),
    .rd_val_b (rf_b),
    .wr_en    (rf_wr),
    .wr_idx   (rf_widx),
    .wr_val   (rf_wval)
  );

  // ALU operand selection
  always_comb begin
    alu_in_a = a_sel ? a_q : pc_q;
    unique case (bsrc_e'(b_sel))
      BSRC_FOUR:  alu_in_b = XLEN'(4);
      BSRC_IMM:   alu_in_b = imm_ext;
      BSRC_IMMSH: alu_in_b = imm_ext << 2;
      default:    alu_in_b = b_q;
    endcase
  end

  mcd_alu_ctrl u_actl (
    .mode  (alu_mode),
    .fcode (ir_q[5:0]),
    .fn    (alu_fn)
  );

  mcd_alu #(.XLEN(XLEN)) u_alu (
    .op_a    (alu_in_a),
    .op_b    (alu_in_b),
    .fn      (alu_fn),
    .result  (alu_y),
    .is_zero (alu_zero)
  );

  // Next program counter
  always_comb begin
    unique case (psrc_e'(pc_src))
      PSRC_LATCH: pc_pick = res_q;
      PSRC_JUMP:  pc_pick = {pc_q[XLEN-1 -: 4], ir_q[JMP_W-1:0], 2'b00};
      default:    pc_pick = alu_y;
    endcase
  end

  assign pc_load = pc_wr | (pc_wr_if_zero & alu_zero);

  // Next-state for all holding registers
  always_comb begin
    pc_d  = pc_load ? pc_pick : pc_q;
    ir_d  = ir_wr ? mem_rdata : ir_q;
    a_d   = rf_a;
    b_d   = rf_b;
    res_d = alu_y;
    mdr_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      mdr_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      a_q   <= a_d;
      b_q   <= b_d;
      res_q <= res_d;
      mdr_q <= mdr_d;
    end
  end

  assign mem_addr  = addr_sel ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_q,
  input logic [31:0] ir_q,
  input logic [31:0] res_q,
  input logic [31:0] mem_rdata,
  input logic        a_sel,
  input logic [1:0]  b_sel,
  input logic [1:0]  alu_mode,
  input logic [1:0]  pc_src,
  input logic        pc_wr,
  input logic        pc_wr_if_zero,
  input logic        ir_wr,
  input logic        alu_zero
);
  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> $stable(ir_q));

  // R3
  ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (ir_q == $past(mem_rdata)));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && !(pc_wr_if_zero && alu_zero)) |=> $stable(pc_q));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'b00 && !a_sel && b_sel == 2'b01 && alu_mode == 2'b00)
      |=> (pc_q == $past(pc_q) + 32'd4));

  // R8
  pc_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && pc_wr_if_zero && alu_zero && pc_src == 2'b01)
      |=> (pc_q == $past(res_q)));

  // R9
  pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'b10)
      |=> (pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00}));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pc_q          (pc_q),
  .ir_q          (ir_q),
  .res_q         (res_q),
  .mem_rdata     (mem_rdata),
  .a_sel         (a_sel),
  .b_sel         (b_sel),
  .alu_mode      (alu_mode),
  .pc_src        (pc_src),
  .pc_wr         (pc_wr),
  .pc_wr_if_zero (pc_wr_if_zero),
  .ir_wr         (ir_wr),
  .alu_zero      (alu_zero)
);

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;

  // {a, b, funct, expected}
  localparam logic [101:0] VEC [NVEC] = '{
    {32'd5,          32'd7,          6'b100000, 32'd12},
    {32'h55,         32'h55,         6'b100010, 32'd0},
    {32'd3,          32'd5,          6'b100010, 32'hFFFF_FFFE},
    {32'hF0F0_00FF,  32'h0FF0_0F0F,  6'b100100, 32'h00F0_000F},
    {32'hF0F0_00FF,  32'h0FF0_0F0F,  6'b100101, 32'hFFF0_0FFF},
    {32'hFFFF_FFFF,  32'd1,          6'b101010, 32'd1},
    {32'd1,          32'hFFFF_FFFF,  6'b101010, 32'd0},
    {32'hFFFF_FFFF,  32'd1,          6'b100000, 32'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic c_iord, c_asel, c_pcw, c_pcc, c_irw, c_rfw, c_dst, c_wb, c_memw;
  logic [1:0] c_bsel, c_aop, c_psrc;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0]  opcode, funct;
  logic        alu_zero;

  logic [31:0] mem [0:255];
  logic        ld_en;
  logic [7:0]  ld_a;
  logic [31:0] ld_d;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] pc_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_datapath dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(c_iord), .a_sel(c_asel), .b_sel(c_bsel),
    .alu_mode(c_aop), .pc_src(c_psrc), .pc_wr(c_pcw), .pc_wr_if_zero(c_pcc),
    .ir_wr(c_irw), .rf_wr(c_rfw), .dst_sel(c_dst), .wb_sel(c_wb),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always_ff @(posedge clk) begin
    if (c_memw)     mem[mem_addr[9:2]] <= mem_wdata;
    else if (ld_en) mem[ld_a] <= ld_d;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic iord, asel, input logic [1:0] bsel, aop, psrc,
                     input logic pcw, pcc, irw, rfw, dst, wb, memw);
    c_iord = iord; c_asel = asel; c_bsel = bsel; c_aop = aop; c_psrc = psrc;
    c_pcw = pcw; c_pcc = pcc; c_irw = irw; c_rfw = rfw; c_dst = dst; c_wb = wb;
    c_memw = memw;
  endtask

  task automatic idle();
    ctl(0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] data);
    ld_a = addr[9:2]; ld_d = data; ld_en = 1'b1;
    step();
    ld_en = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] instr);
    poke(pc_exp, instr);
    ctl(0, 0, 2'b01, 2'b00, 2'b00, 1, 0, 1, 0, 0, 0, 0);
    step();
    pc_exp = pc_exp + 32'd4;
    chk("R4 pc+4 after fetch", mem_addr, pc_exp);
    chk("R3 opcode loaded", {26'd0, opcode}, {26'd0, instr[31:26]});
  endtask

  task automatic decode();
    ctl(0, 0, 2'b11, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    step();
  endtask

  task automatic load(input logic [4:0] rt, rs, input logic [15:0] imm,
                      input logic [31:0] exp_addr);
    fetch({6'h23, rs, rt, imm});
    decode();
    ctl(0, 1, 2'b10, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    step();
    ctl(1, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R5 R2 load address", mem_addr, exp_addr);
    step();
    chk("R3 IR held during data read", {26'd0, opcode}, 32'h23);
    ctl(0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 1, 0, 1, 0);
    step();
  endtask

  task automatic read_reg(input logic [4:0] r, input logic [31:0] exp, input string tag);
    fetch({6'h3f, 5'd0, r, 16'd0});
    decode();
    chk(tag, mem_wdata, exp);
  endtask

  task automatic rtype(input logic [4:0] rs, rt, rd, input logic [5:0] fc,
                       input logic [31:0] exp);
    fetch({6'h00, rs, rt, rd, 5'd0, fc});
    chk("R3 funct field", {26'd0, funct}, {26'd0, fc});
    decode();
    ctl(0, 1, 2'b00, 2'b10, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R6 zero flag", {31'd0, alu_zero}, {31'd0, (exp == 32'd0)});
    step();
    c_iord = 1'b1;
    #1;
    chk("R7 R2 alu result latch", mem_addr, exp);
    ctl(0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 1, 1, 0, 0);
    step();
  endtask

  initial begin
    ld_en = 1'b0; ld_a = '0; ld_d = '0;
    idle();
    pc_exp = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    chk("R1 pc reset", mem_addr, 32'h0);
    chk("R1 opcode reset", {26'd0, opcode}, 32'd0);
    chk("R1 funct reset", {26'd0, funct}, 32'd0);
    chk("R12 R1 B latch reset", mem_wdata, 32'd0);

    // Vector table through the funct-decoded ALU path
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] va, vb, ve;
      logic [5:0]  vf;
      {va, vb, vf, ve} = VEC[v];
      poke(32'h200, va);
      poke(32'h204, vb);
      load(5'd1, 5'd0, 16'h0200, 32'h200);
      load(5'd2, 5'd0, 16'h0204, 32'h204);
      rtype(5'd1, 5'd2, 5'd3, vf, ve);
      read_reg(5'd3, ve, "R10 R7 rd written with ALU result");
    end
    read_reg(5'd2, VEC[NVEC-1][69:38], "R10 rt untouched by rd write");

    // R11 register 0
    load(5'd0, 5'd0, 16'h0200, 32'h200);
    read_reg(5'd0, 32'd0, "R11 r0 after load");
    rtype(5'd1, 5'd2, 5'd0, 6'b100101, 32'hFFFF_FFFF);
    read_reg(5'd0, 32'd0, "R11 r0 after rtype write");

    // R5 negative immediate
    poke(32'h208, 32'h210);
    poke(32'h20C, 32'h0000_ABCD);
    load(5'd5, 5'd0, 16'h0208, 32'h208);
    load(5'd6, 5'd5, 16'hFFFC, 32'h20C);
    read_reg(5'd6, 32'h0000_ABCD, "R10 load data via memory latch");

    // R8 branch taken
    load(5'd8, 5'd0, 16'h0208, 32'h208);
    fetch({6'h04, 5'd5, 5'd8, 16'h0003});
    decode();
    c_iord = 1'b1;
    #1;
    chk("R5 shifted immediate target", mem_addr, pc_exp + 32'd12);
    ctl(0, 1, 2'b00, 2'b01, 2'b01, 0, 1, 0, 0, 0, 0, 0);
    #1;
    chk("R6 zero on equal subtract", {31'd0, alu_zero}, 32'd1);
    step();
    pc_exp = pc_exp + 32'd12;
    chk("R8 branch taken", mem_addr, pc_exp);

    // R8 branch not taken
    fetch({6'h04, 5'd5, 5'd6, 16'h0003});
    decode();
    ctl(0, 1, 2'b00, 2'b01, 2'b01, 0, 1, 0, 0, 0, 0, 0);
    #1;
    chk("R6 zero low on unequal", {31'd0, alu_zero}, 32'd0);
    step();
    chk("R8 branch not taken", mem_addr, pc_exp);

    // R12 store
    fetch({6'h2b, 5'd0, 5'd5, 16'h0220});
    decode();
    ctl(0, 1, 2'b10, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    step();
    ctl(1, 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1);
    #1;
    chk("R12 store data", mem_wdata, 32'h210);
    chk("R2 store address", mem_addr, 32'h220);
    step();
    load(5'd7, 5'd0, 16'h0220, 32'h220);
    read_reg(5'd7, 32'h210, "R12 stored word read back");

    // R9 jump
    fetch({6'h02, 26'h0000040});
    ctl(0, 0, 2'b00, 2'b00, 2'b10, 1, 0, 0, 0, 0, 0, 0);
    step();
    pc_exp = {pc_exp[31:28], 26'h0000040, 2'b00};
    chk("R9 jump target", mem_addr, pc_exp);
    read_reg(5'd6, 32'h0000_ABCD, "R9 execution continues after jump");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule